// File: doc/BRIEF.md
# Batch-Ranked DRAM Request Picker

This block chooses which pending DRAM request goes out next. A request queue outside the block holds a fixed number of slots. Each slot carries a valid bit, a ready bit (set by the timing logic once the command may legally go out), an issuing thread, a target bank, a target row and an age, where a larger age means an older request. The block also sees, for every bank, whether a row is open and which one. Each cycle it raises an issue strobe with the index of the winning slot, or holds the strobe low when nothing can go.

Fairness comes from batches. When no marked request is left in the queue, the block marks a new batch. For every pairing of thread and bank, only the few oldest requests are marked, and the cap is a parameter. In the same cycle it counts how many requests each thread has queued and freezes a thread ranking: threads with fewer queued requests rank higher. Between batches the ranking does not change. Selection is lexicographic. Batch membership counts first, then a hit on the open row, then thread rank, then age, then the lower slot index.

The queue owner removes an issued slot from the queue. A slot only takes a new request after it has been issued or shown invalid for at least one clock edge.

Top module: `bsch_top`

## Requirements
- R1: When no slot is both valid and ready, `issue_valid` is 0 and `issue_idx` is 0.
- R2: A batch is formed only in a cycle where no valid slot is marked. At formation, each (thread, bank) pair gets at most CAP marked slots, and these are its oldest. Age is compared first, with a larger age being older. At equal age the lower slot index counts as older.
- R3: A marked valid ready slot always wins over an unmarked one.
- R4: Among slots with the same mark status, a row hit wins over a miss. A slot hits when `bank_open` is 1 for its bank and that bank's entry in `bank_row` equals the slot's row.
- R5: After the mark and hit criteria, the slot whose thread has the better rank wins.
- R6: A thread's intensity is its number of valid slots at batch formation. Rank order follows ascending intensity, and equal intensity goes to the lower thread ID. Ranks stay frozen until the next formation.
- R7: After rank, the larger age wins. At equal age, the lower slot index wins.
- R8: A slot whose ready bit is 0 is never selected, but it can still be marked at formation.
- R9: A slot loses its mark when it is issued or when its valid bit is 0 at a clock edge. A request placed into that slot later therefore starts unmarked.
- R10: In the cycle a batch is formed, selection already uses the new marks and ranks, so formation costs no issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_valid | input | ENTRIES | Slot holds a request |
| ent_ready | input | ENTRIES | Slot may issue this cycle |
| ent_thread | input | ENTRIES*TW | Thread ID per slot, slot e at bits e*TW |
| ent_bank | input | ENTRIES*BW | Bank per slot, slot e at bits e*BW |
| ent_row | input | ENTRIES*ROW_W | Row per slot |
| ent_age | input | ENTRIES*AGE_W | Age per slot, larger is older |
| bank_open | input | BANKS | Bank has an open row |
| bank_row | input | BANKS*ROW_W | Open row per bank |
| issue_valid | output | 1 | A slot is selected this cycle |
| issue_idx | output | IW | Index of the selected slot |

## Verification
The frozen ranking is the hardest behaviour to reach from the ports. It only shows when two marked slots from different threads compete and the queue contents have since changed enough that a fresh count would reverse their order. The bench builds such a batch. It then adds several not-ready requests from the favoured thread, which a fresh count would push below the other thread, and checks that the favoured thread still wins. The per-pair cap is also observed only indirectly, through an older unmarked request that must lose to a later batch containing a row hit. After the directed cases, a long pseudo-random run compares every cycle against an arithmetic model.

// File: rtl/bsch_pkg.sv
// Shared defaults and helpers for the batch-ranked request picker.
package bsch_pkg;
    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_THREADS = 4;
    localparam int unsigned DEF_BANKS   = 4;
    localparam int unsigned DEF_ROW_W   = 8;
    localparam int unsigned DEF_AGE_W   = 8;
    localparam int unsigned DEF_CAP     = 2;

    // Width of an index into n items, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bsch_batch_marker.sv
// Holds the batch mark of every slot and forms a new batch when the
// queue holds no marked valid request. At formation each (thread, bank)
// pair gets up to CAP marks on its oldest slots. Assumes the queue owner
// does not refill a slot before it was issued or seen invalid at an edge.
module bsch_batch_marker
    import bsch_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned THREADS = DEF_THREADS,
    parameter int unsigned BANKS   = DEF_BANKS,
    parameter int unsigned AGE_W   = DEF_AGE_W,
    parameter int unsigned CAP     = DEF_CAP,
    localparam int unsigned TW     = idx_w(THREADS),
    localparam int unsigned BW     = idx_w(BANKS),
    localparam int unsigned IW     = idx_w(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ENTRIES-1:0]       ent_valid,
    input  logic [ENTRIES*TW-1:0]    ent_thread,
    input  logic [ENTRIES*BW-1:0]    ent_bank,
    input  logic [ENTRIES*AGE_W-1:0] ent_age,
    input  logic                     issue_valid,
    input  logic [IW-1:0]            issue_idx,
    output logic                     form_batch,
    output logic [ENTRIES-1:0]       mark_eff
);
    logic [ENTRIES-1:0] mark_q;
    logic [ENTRIES-1:0] mark_new;
    logic [ENTRIES-1:0] issue_vec;
    logic [ENTRIES-1:0] live_marks;

    // Marks still attached to valid slots.
    assign live_marks = mark_q & ent_valid;
    // A batch is formed when requests exist but none is marked.
    assign form_batch = (live_marks == '0) && (ent_valid != '0);

    // Rank each slot among its (thread, bank) peers by age; mark the oldest CAP.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            int older;
            older = 0;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != i && ent_valid[j]
                    && ent_thread[j*TW +: TW] == ent_thread[i*TW +: TW]
                    && ent_bank[j*BW +: BW] == ent_bank[i*BW +: BW]
                    && (ent_age[j*AGE_W +: AGE_W] > ent_age[i*AGE_W +: AGE_W]
                        || (ent_age[j*AGE_W +: AGE_W] == ent_age[i*AGE_W +: AGE_W] && j < i)))
                    older = older + 1;
            end
            mark_new[i] = ent_valid[i] && (older < int'(CAP));
        end
    end

    // Bypass the new batch into this cycle's selection.
    assign mark_eff = form_batch ? mark_new : live_marks;

    // One-hot of the slot leaving the queue this cycle.
    always_comb begin
        issue_vec = '0;
        if (issue_valid) issue_vec[issue_idx] = 1'b1;
    end

    // Keep marks for slots that stay; drop the issued one.
    always_ff @(posedge clk) begin
        if (!rst_n) mark_q <= '0;
        else        mark_q <= mark_eff & ~issue_vec;
    end

    AST_BATCH_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        form_batch |-> (mark_eff != '0)); // R2

    for (genvar gt = 0; gt < THREADS; gt++) begin : g_thr
        for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
            logic [ENTRIES-1:0] grp;
            // Slots of this pair that the new batch marks.
            always_comb begin
                for (int e = 0; e < ENTRIES; e++)
                    grp[e] = mark_new[e]
                             && ent_thread[e*TW +: TW] == TW'(gt)
                             && ent_bank[e*BW +: BW] == BW'(gb);
            end
            AST_PAIR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                form_batch |-> ($countones(grp) <= int'(CAP))); // R2
        end
    end
endmodule

// File: rtl/bsch_thread_ranker.sv
// Counts valid slots per thread and, at batch formation, orders threads
// by ascending count (ties to the lower thread ID). Rank 0 is best.
// The ranking is held until the next formation.
module bsch_thread_ranker
    import bsch_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned THREADS = DEF_THREADS,
    localparam int unsigned TW     = idx_w(THREADS),
    localparam int unsigned CW     = idx_w(ENTRIES) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ENTRIES-1:0]    ent_valid,
    input  logic [ENTRIES*TW-1:0] ent_thread,
    input  logic                  form_batch,
    output logic [THREADS*TW-1:0] rank_eff
);
    logic [CW-1:0]   load  [THREADS];
    logic [TW-1:0]   rk_new[THREADS];
    logic [TW-1:0]   rk_q  [THREADS];
    logic [THREADS-1:0] seen;

    // Per-thread count of queued requests.
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            load[t] = '0;
            for (int e = 0; e < ENTRIES; e++)
                if (ent_valid[e] && ent_thread[e*TW +: TW] == TW'(t))
                    load[t] = load[t] + 1'b1;
        end
    end

    // Rank = number of threads ordered ahead of this one.
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            int ahead;
            ahead = 0;
            for (int u = 0; u < THREADS; u++)
                if (load[u] < load[t] || (load[u] == load[t] && u < t))
                    ahead = ahead + 1;
            rk_new[t] = TW'(ahead);
        end
    end

    // Freeze the ranking at formation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < THREADS; t++) rk_q[t] <= TW'(t);
        end else if (form_batch) begin
            for (int t = 0; t < THREADS; t++) rk_q[t] <= rk_new[t];
        end
    end

    for (genvar gt = 0; gt < THREADS; gt++) begin : g_out
        assign rank_eff[gt*TW +: TW] = form_batch ? rk_new[gt] : rk_q[gt];
    end

    // Which rank values the stored ranking occupies.
    always_comb begin
        seen = '0;
        for (int t = 0; t < THREADS; t++) seen[rk_q[t]] = 1'b1;
    end

    AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        (&seen)); // R6
endmodule

// File: rtl/bsch_pick.sv
// Chooses the best valid ready slot by {mark, row hit, thread rank, age};
// a full tie goes to the lower index. Purely combinational.
module bsch_pick
    import bsch_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned THREADS = DEF_THREADS,
    parameter int unsigned AGE_W   = DEF_AGE_W,
    localparam int unsigned TW     = idx_w(THREADS),
    localparam int unsigned IW     = idx_w(ENTRIES),
    localparam int unsigned KW     = 2 + TW + AGE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ENTRIES-1:0]       ent_valid,
    input  logic [ENTRIES-1:0]       ent_ready,
    input  logic [ENTRIES-1:0]       ent_mark,
    input  logic [ENTRIES-1:0]       ent_hit,
    input  logic [ENTRIES*TW-1:0]    ent_rank,
    input  logic [ENTRIES*AGE_W-1:0] ent_age,
    output logic                     issue_valid,
    output logic [IW-1:0]            issue_idx
);
    logic [KW-1:0]      key [ENTRIES];
    logic [ENTRIES-1:0] cand;
    logic [KW-1:0]      best_key;

    assign cand = ent_valid & ent_ready;

    // Priority key, larger is better; rank is inverted so rank 0 scores highest.
    for (genvar ge = 0; ge < ENTRIES; ge++) begin : g_key
        assign key[ge] = {ent_mark[ge], ent_hit[ge],
                          TW'(THREADS - 1) - ent_rank[ge*TW +: TW],
                          ent_age[ge*AGE_W +: AGE_W]};
    end

    // Ascending scan with strict compare keeps the lower index on ties.
    always_comb begin
        issue_valid = 1'b0;
        issue_idx   = '0;
        best_key    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cand[i] && (!issue_valid || key[i] > best_key)) begin
                issue_valid = 1'b1;
                issue_idx   = IW'(i);
                best_key    = key[i];
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> (!issue_valid && issue_idx == '0)); // R1
    AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (ent_valid[issue_idx] && ent_ready[issue_idx])); // R8
    AST_MARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (cand & ent_mark) != '0) |-> ent_mark[issue_idx]); // R3
    AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ent_mark[issue_idx] && (cand & ent_mark & ent_hit) != '0)
        |-> ent_hit[issue_idx]); // R4
endmodule

// File: rtl/bsch_top.sv
// Batch-ranked DRAM request picker. Derives the row-hit flag and the
// thread rank of every slot and feeds the marker, ranker and picker.
// Assumes ready bits already include all DRAM timing checks.
module bsch_top
    import bsch_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned THREADS = DEF_THREADS,
    parameter int unsigned BANKS   = DEF_BANKS,
    parameter int unsigned ROW_W   = DEF_ROW_W,
    parameter int unsigned AGE_W   = DEF_AGE_W,
    parameter int unsigned CAP     = DEF_CAP,
    localparam int unsigned TW     = idx_w(THREADS),
    localparam int unsigned BW     = idx_w(BANKS),
    localparam int unsigned IW     = idx_w(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ENTRIES-1:0]       ent_valid,
    input  logic [ENTRIES-1:0]       ent_ready,
    input  logic [ENTRIES*TW-1:0]    ent_thread,
    input  logic [ENTRIES*BW-1:0]    ent_bank,
    input  logic [ENTRIES*ROW_W-1:0] ent_row,
    input  logic [ENTRIES*AGE_W-1:0] ent_age,
    input  logic [BANKS-1:0]         bank_open,
    input  logic [BANKS*ROW_W-1:0]   bank_row,
    output logic                     issue_valid,
    output logic [IW-1:0]            issue_idx
);
    logic                  form_batch;
    logic [ENTRIES-1:0]    mark_eff;
    logic [ENTRIES-1:0]    hit;
    logic [THREADS*TW-1:0] rank_eff;
    logic [ENTRIES*TW-1:0] ent_rank;

    // Per-slot row-hit flag and the rank of the slot's thread.
    for (genvar ge = 0; ge < ENTRIES; ge++) begin : g_slot
        logic [BW-1:0] b;
        logic [TW-1:0] t;
        assign b = ent_bank[ge*BW +: BW];
        assign t = ent_thread[ge*TW +: TW];
        assign hit[ge] = bank_open[b]
                         && bank_row[b*ROW_W +: ROW_W] == ent_row[ge*ROW_W +: ROW_W];
        assign ent_rank[ge*TW +: TW] = rank_eff[t*TW +: TW];
    end

    bsch_batch_marker #(
        .ENTRIES(ENTRIES), .THREADS(THREADS), .BANKS(BANKS),
        .AGE_W(AGE_W), .CAP(CAP)
    ) marker_i (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_thread(ent_thread),
        .ent_bank(ent_bank), .ent_age(ent_age),
        .issue_valid(issue_valid), .issue_idx(issue_idx),
        .form_batch(form_batch), .mark_eff(mark_eff)
    );

    bsch_thread_ranker #(
        .ENTRIES(ENTRIES), .THREADS(THREADS)
    ) ranker_i (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_thread(ent_thread),
        .form_batch(form_batch), .rank_eff(rank_eff)
    );

    bsch_pick #(
        .ENTRIES(ENTRIES), .THREADS(THREADS), .AGE_W(AGE_W)
    ) pick_i (
        .clk(clk), .rst_n(rst_n),
        .ent_valid(ent_valid), .ent_ready(ent_ready),
        .ent_mark(mark_eff), .ent_hit(hit),
        .ent_rank(ent_rank), .ent_age(ent_age),
        .issue_valid(issue_valid), .issue_idx(issue_idx)
    );
endmodule

// File: tb/bsch_top_tb_top.sv
// Directed cases followed by a pseudo-random run, all compared against an
// arithmetic model of the selection rules.
module bsch_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int E = 8, T = 4, B = 4, RW = 8, AW = 8, CAP = 2;
    localparam int TW = 2, BW = 2, IW = 3;

    logic clk = 0, rst_n = 0;
    logic [E-1:0] ent_valid, ent_ready;
    logic [E*TW-1:0] ent_thread;
    logic [E*BW-1:0] ent_bank;
    logic [E*RW-1:0] ent_row;
    logic [E*AW-1:0] ent_age;
    logic [B-1:0] bank_open;
    logic [B*RW-1:0] bank_row;
    logic issue_valid;
    logic [IW-1:0] issue_idx;

    bit v[E], rdy[E];
    int th[E], bk[E], rw[E], ag[E];
    bit bo[B];
    int br[B];
    bit mmark[E];
    int mrank[T];
    int errors = 0, checks = 0;
    bit done = 0;
    bit [31:0] lf = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack bench arrays onto the flat ports.
    always_comb begin
        for (int e = 0; e < E; e++) begin
            ent_valid[e] = v[e];
            ent_ready[e] = rdy[e];
            ent_thread[e*TW +: TW] = TW'(th[e]);
            ent_bank[e*BW +: BW] = BW'(bk[e]);
            ent_row[e*RW +: RW] = RW'(rw[e]);
            ent_age[e*AW +: AW] = AW'(ag[e]);
        end
        for (int b = 0; b < B; b++) begin
            bank_open[b] = bo[b];
            bank_row[b*RW +: RW] = RW'(br[b]);
        end
    end

    bsch_top #(.ENTRIES(E), .THREADS(T), .BANKS(B), .ROW_W(RW), .AGE_W(AW), .CAP(CAP))
        dut_i (.clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
               .ent_thread(ent_thread), .ent_bank(ent_bank), .ent_row(ent_row),
               .ent_age(ent_age), .bank_open(bank_open), .bank_row(bank_row),
               .issue_valid(issue_valid), .issue_idx(issue_idx));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic bit [31:0] rnd();
        lf = lf ^ (lf << 13);
        lf = lf ^ (lf >> 17);
        lf = lf ^ (lf << 5);
        return lf;
    endfunction

    task automatic put(input int s, input int t, input int b, input int r, input int a, input bit rd);
        v[s] = 1; th[s] = t; bk[s] = b; rw[s] = r; ag[s] = a; rdy[s] = rd;
    endtask

    task automatic clr_all();
        for (int e = 0; e < E; e++) begin v[e] = 0; rdy[e] = 0; end
        for (int b = 0; b < B; b++) bo[b] = 0;
    endtask

    // hand: slot index expected by hand, -1 none given, -2 no issue expected.
    task automatic step(input string tag, input int hand);
        bit form_m, any_live, any_v;
        bit effm[E];
        int effr[T], cnt[T];
        int exp_idx;
        bit exp_v;
        longint best, k;
        #1;
        any_live = 0; any_v = 0;
        for (int e = 0; e < E; e++) begin
            if (v[e]) any_v = 1;
            if (v[e] && mmark[e]) any_live = 1;
        end
        form_m = any_v && !any_live;
        for (int t = 0; t < T; t++) begin
            cnt[t] = 0;
            for (int e = 0; e < E; e++) if (v[e] && th[e] == t) cnt[t]++;
        end
        for (int i = 0; i < E; i++) begin
            if (form_m) begin
                int older = 0;
                for (int j = 0; j < E; j++)
                    if (j != i && v[j] && th[j] == th[i] && bk[j] == bk[i]
                        && (ag[j] > ag[i] || (ag[j] == ag[i] && j < i))) older++;
                effm[i] = v[i] && older < CAP;
            end else effm[i] = v[i] && mmark[i];
        end
        for (int t = 0; t < T; t++) begin
            if (form_m) begin
                int ahead = 0;
                for (int u = 0; u < T; u++)
                    if (cnt[u] < cnt[t] || (cnt[u] == cnt[t] && u < t)) ahead++;
                effr[t] = ahead;
            end else effr[t] = mrank[t];
        end
        exp_v = 0; exp_idx = 0; best = -1;
        for (int e = 0; e < E; e++) begin
            if (v[e] && rdy[e]) begin
                k = ((longint'(effm[e]) * 2 + longint'(bo[bk[e]] && br[bk[e]] == rw[e])) * T
                     + (T - 1 - effr[th[e]])) * 256 + ag[e];
                if (k > best) begin best = k; exp_idx = e; exp_v = 1; end
            end
        end
        chk(issue_valid == exp_v, {tag, " strobe"}, issue_valid, exp_v);
        if (exp_v) chk(int'(issue_idx) == exp_idx, {tag, " index"}, issue_idx, exp_idx);
        else chk(issue_idx == 0, {tag, " idle index"}, issue_idx, 0);
        if (hand == -2) chk(!issue_valid, {tag, " hand strobe"}, issue_valid, 0);
        else if (hand >= 0)
            chk(issue_valid && int'(issue_idx) == hand, {tag, " hand index"}, issue_idx, hand);
        for (int e = 0; e < E; e++) mmark[e] = effm[e] && !(exp_v && e == exp_idx);
        if (form_m) for (int t = 0; t < T; t++) mrank[t] = effr[t];
        @(posedge clk);
        @(negedge clk);
        if (exp_v) begin v[exp_idx] = 0; rdy[exp_idx] = 0; end
        for (int e = 0; e < E; e++) if (v[e] && ag[e] < 255) ag[e]++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clr_all();
        for (int e = 0; e < E; e++) begin th[e] = 0; bk[e] = 0; rw[e] = 0; ag[e] = 0; mmark[e] = 0; end
        for (int t = 0; t < T; t++) mrank[t] = t;
        for (int b = 0; b < B; b++) br[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        step("R1 reset idle", -2);

        // Rank wins over age inside the batch; formation issues at once.
        put(0, 0, 0, 1, 30, 1); put(1, 0, 0, 1, 20, 1);
        put(2, 0, 0, 1, 10, 1); put(3, 1, 0, 1, 5, 1);
        step("R5 R10 rank", 3);
        put(4, 2, 0, 7, 100, 1); bo[0] = 1; br[0] = 7;
        step("R3 marked over old hit", 0);
        step("R7 age in batch", 1);
        step("R2 cap left slot2 out", 4);
        step("R4 follow-up", 2);
        step("R1 empty", -2);

        // Not-ready slots are marked but never picked.
        bo[0] = 0;
        put(0, 0, 1, 0, 10, 0); put(1, 1, 2, 0, 10, 0); put(2, 2, 3, 0, 10, 0);
        step("R8 none ready", -2);
        rdy[1] = 1;
        step("R8 one ready", 1);
        v[0] = 0; v[2] = 0;
        step("R1 drained", -2);
        put(0, 3, 0, 1, 1, 1); put(7, 2, 0, 7, 50, 1); bo[0] = 1; br[0] = 7;
        step("R9 stale mark", 7);
        step("R7 last", 0);

        // Equal intensity: lower thread ID ranks better.
        bo[0] = 0;
        put(0, 2, 1, 0, 5, 1); put(5, 1, 2, 0, 5, 1);
        step("R6 tie", 5);
        step("R7 single", 0);

        // Ranks frozen while the batch lasts.
        put(0, 0, 0, 0, 9, 1); put(1, 0, 1, 0, 9, 1);
        put(2, 1, 0, 0, 1, 1); put(3, 1, 1, 0, 1, 1); put(4, 1, 2, 0, 1, 1);
        step("R5 low intensity", 0);
        put(5, 0, 3, 0, 0, 0); put(6, 0, 3, 0, 0, 0); put(7, 0, 3, 0, 0, 0);
        step("R6 frozen", 1);
        clr_all();
        step("R1 cleared", -2);

        // Equal age, same thread and bank: lower index first.
        put(2, 1, 0, 0, 20, 1); put(6, 1, 0, 0, 20, 1);
        step("R7 index tie", 2);
        step("R7 index tie 2", 6);

        // Pseudo-random traffic against the model.
        for (int c = 0; c < 3000; c++) begin
            for (int e = 0; e < E; e++) begin
                bit [31:0] r = rnd();
                if (!v[e] && r[2:0] == 0)
                    put(e, int'(r[9:8]), int'(r[11:10]), int'(r[13:12]), 0, r[14]);
                else if (v[e] && r[4:3] == 0) rdy[e] = r[15];
            end
            if (c % 16 == 0)
                for (int b = 0; b < B; b++) begin
                    bit [31:0] r = rnd();
                    bo[b] = r[0]; br[b] = int'(r[2:1]);
                end
            step("R7 random model", -1);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule